// File: doc/BRIEF.md
# Per-Line Video Gain Servo

This block runs the digital side of a three-channel video gain calibration. It is built for a triple ADC front end that carries red, green and blue. During each horizontal sync pulse, the front end feeds a fixed reference level to every channel. The block waits a set number of clocks for that level to settle, then takes one ADC sample per channel. It compares each sample with that channel's programmed target code and moves that channel's coarse gain code by one step toward the target. Over many lines, each channel's gain converges so that the reference lands on its target code.

Each channel also has a 5-bit fine trim. The trim goes straight to the gain DAC and corrects mismatch between channels. A per-channel lock flag reports when a channel has held its sample within a programmable tolerance of its target for several lines in a row. The video-valid output is low for the whole sync pulse, because during sync the ADC codes show the reference and not the picture.

Software writes settings through a plain single-cycle parallel write port. The ADC input has no valid/ready handshake. It carries one code per channel on every clock, and the block never applies back-pressure because an ADC cannot be stalled. Every output is a plain level.

Top module: `vgc_gain_servo`

## Requirements
- R1: A synchronous active-high reset sets every coarse gain code to mid-scale (64), every target to 64, every fine trim to 0, the tolerance to 4 and every lock flag to 0. The video-valid output is 0 during reset and 1 afterwards while hsync is low.
- R2: A write to address 4*c+0 (c = 0 red, 1 green, 2 blue) sets channel c's target. The full 8-bit write data is clamped into 32..99: values below 32 are stored as 32 and values above 99 as 99.
- R3: A write to address 4*c+1 loads wr_data[4:0] into channel c's fine trim. The trim appears on fine_gain bits [5c+4:5c] one clock after the write. It changes at no other time.
- R4: On each sync pulse that is long enough, every channel's coarse gain moves exactly once. It rises by 1 when the sample is below the target, falls by 1 when the sample is above, and holds when they are equal. The gain never changes while hsync is low.
- R5: The coarse gain code saturates: it stays at 127 when a step up is requested and at 0 when a step down is requested.
- R6: The compared sample is the ADC code at the (SETTLE_CLKS+1)-th rising clock edge at which hsync is high, counting from the start of the pulse (default SETTLE_CLKS = 3). A pulse that is high for SETTLE_CLKS edges or fewer changes nothing.
- R7: video_valid is 0 whenever hsync is 1.
- R8: A channel's lock flag goes to 1 after LOCK_LINES (default 4) consecutive sampled lines with |sample - target| <= tolerance. It returns to 0 on the first sampled line outside the tolerance.
- R9: A write to address 12 loads wr_data[3:0] into the tolerance that all three channels share.
- R10: The channels are independent: one channel's sample and settings never affect another channel's gain, trim or lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| hsync | input | 1 | Horizontal sync; reference injected while high |
| adc_code | input | 24 | ADC codes, red in [7:0], green in [15:8], blue in [23:16] |
| coarse_gain | output | 21 | Coarse gain codes, 7 bits per channel, red lowest |
| fine_gain | output | 15 | Fine trim codes, 5 bits per channel, red lowest |
| locked | output | 3 | Per-channel lock flags, bit 0 red |
| video_valid | output | 1 | High when the ADC codes are live video |

## Verification
On every clock, the assertions check these properties:
- video_valid stays low during sync.
- A coarse gain code moves by at most one count, and only just after a clock that saw sync high.
- The fine trims change only after a write.
- The stored targets never leave 32..99.
- A lock flag rises only while sync is high.

Some behaviours can only be shown by the directed scenarios. These are the direction of each step relative to the target, which ADC sample is taken after settling, the clamping of out-of-range target writes, saturation at both ends of the gain range, and the lock count together with its loss. The bench checks them against its own per-channel model of gain, target, tolerance and lock run.

// File: rtl/vgc_pkg.sv
package vgc_pkg;
  // Field selected by wr_addr[1:0] inside a channel slot
  typedef enum logic [1:0] {
    FLD_TARGET = 2'd0,
    FLD_FINE   = 2'd1
  } vgc_field_e;

  // Slot value in wr_addr[3:2] that holds the shared settings
  localparam logic [1:0] SHARED_SLOT = 2'd3;

  // Direction decided for one line
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } vgc_step_e;
endpackage

// File: rtl/vgc_regs.sv
module vgc_regs
  import vgc_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int DATA_W  = 8,
  parameter int TGT_W   = 7,
  parameter int FINE_W  = 5,
  parameter int TOL_W   = 4,
  parameter int TGT_MIN = 32,
  parameter int TGT_MAX = 99,
  parameter int TGT_RST = 64,
  parameter int TOL_RST = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [3:0]              wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [NCH*TGT_W-1:0]    target_flat,
  output logic [NCH*FINE_W-1:0]   fine_flat,
  output logic [TOL_W-1:0]        tol
);
  localparam logic [DATA_W-1:0] MIN_D = DATA_W'(TGT_MIN);
  localparam logic [DATA_W-1:0] MAX_D = DATA_W'(TGT_MAX);

  logic [TGT_W-1:0] tgt_clamped;

  always_comb begin
    if (wr_data < MIN_D)      tgt_clamped = TGT_W'(TGT_MIN);
    else if (wr_data > MAX_D) tgt_clamped = TGT_W'(TGT_MAX);
    else                      tgt_clamped = wr_data[TGT_W-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    logic hit_tgt, hit_fine;
    assign hit_tgt  = wr_en && (wr_addr[3:2] == 2'(c)) && (wr_addr[1:0] == FLD_TARGET);
    assign hit_fine = wr_en && (wr_addr[3:2] == 2'(c)) && (wr_addr[1:0] == FLD_FINE);

    always_ff @(posedge clk) begin
      if (rst) begin
        target_flat[c*TGT_W +: TGT_W] <= TGT_W'(TGT_RST);
        fine_flat[c*FINE_W +: FINE_W] <= '0;
      end else begin
        if (hit_tgt)  target_flat[c*TGT_W +: TGT_W] <= tgt_clamped;
        if (hit_fine) fine_flat[c*FINE_W +: FINE_W] <= wr_data[FINE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tol <= TOL_W'(TOL_RST);
    else if (wr_en && wr_addr[3:2] == SHARED_SLOT && wr_addr[1:0] == 2'd0)
      tol <= wr_data[TOL_W-1:0];
  end
endmodule

// File: rtl/vgc_line_timer.sv
module vgc_line_timer #(
  parameter int SETTLE_CLKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hsync,
  output logic sample_stb
);
  localparam int CNT_W = $clog2(SETTLE_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE_CLKS);

  logic             hsync_d;
  logic             taken;
  logic [CNT_W-1:0] cnt;

  // cnt equals the number of high edges seen so far, capped at CNT_END
  assign sample_stb = hsync && hsync_d && (cnt == CNT_END) && !taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_d <= 1'b0;
      cnt     <= '0;
      taken   <= 1'b0;
    end else begin
      hsync_d <= hsync;
      if (!hsync) begin
        cnt   <= '0;
        taken <= 1'b0;
      end else if (!hsync_d) begin
        cnt   <= CNT_W'(1);
        taken <= 1'b0;
      end else begin
        if (cnt != CNT_END) cnt <= cnt + 1'b1;
        if (sample_stb)     taken <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vgc_chan_loop.sv
module vgc_chan_loop
  import vgc_pkg::*;
#(
  parameter int ADC_W      = 8,
  parameter int GAIN_W     = 7,
  parameter int TGT_W      = 7,
  parameter int TOL_W      = 4,
  parameter int LOCK_LINES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_stb,
  input  logic [ADC_W-1:0]  adc_code,
  input  logic [TGT_W-1:0]  target,
  input  logic [TOL_W-1:0]  tol,
  output logic [GAIN_W-1:0] gain,
  output logic              locked
);
  localparam int LK_W = $clog2(LOCK_LINES + 1);
  localparam logic [LK_W-1:0]   LK_END   = LK_W'(LOCK_LINES);
  localparam logic [GAIN_W-1:0] GAIN_MID = {1'b1, {(GAIN_W-1){1'b0}}};
  localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

  logic [ADC_W-1:0] tgt_ext, tol_ext, mag;
  logic             in_tol;
  vgc_step_e        step;
  logic [LK_W-1:0]  run;

  assign tgt_ext = {{(ADC_W-TGT_W){1'b0}}, target};
  assign tol_ext = {{(ADC_W-TOL_W){1'b0}}, tol};

  always_comb begin
    if (adc_code < tgt_ext) begin
      step = STEP_UP;
      mag  = tgt_ext - adc_code;
    end else if (adc_code > tgt_ext) begin
      step = STEP_DOWN;
      mag  = adc_code - tgt_ext;
    end else begin
      step = STEP_HOLD;
      mag  = '0;
    end
  end

  assign in_tol = (mag <= tol_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      gain <= GAIN_MID;
      run  <= '0;
    end else if (sample_stb) begin
      unique case (step)
        STEP_UP:   if (gain != GAIN_MAX) gain <= gain + 1'b1;
        STEP_DOWN: if (gain != '0)       gain <= gain - 1'b1;
        default:   gain <= gain;
      endcase
      if (!in_tol)            run <= '0;
      else if (run != LK_END) run <= run + 1'b1;
    end
  end

  assign locked = (run == LK_END);
endmodule

// File: rtl/vgc_gain_servo.sv
module vgc_gain_servo #(
  parameter int NCH         = 3,
  parameter int ADC_W       = 8,
  parameter int GAIN_W      = 7,
  parameter int FINE_W      = 5,
  parameter int TOL_W       = 4,
  parameter int SETTLE_CLKS = 3,
  parameter int LOCK_LINES  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [3:0]             wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   hsync,
  input  logic [NCH*ADC_W-1:0]   adc_code,
  output logic [NCH*GAIN_W-1:0]  coarse_gain,
  output logic [NCH*FINE_W-1:0]  fine_gain,
  output logic [NCH-1:0]         locked,
  output logic                   video_valid
);
  localparam int TGT_W = 7;

  logic [NCH*TGT_W-1:0] target_flat;
  logic [TOL_W-1:0]     tol;
  logic                 sample_stb;
  logic                 out_live;

  vgc_regs #(
    .NCH(NCH), .DATA_W(8), .TGT_W(TGT_W), .FINE_W(FINE_W), .TOL_W(TOL_W),
    .TGT_MIN(32), .TGT_MAX(99), .TGT_RST(64), .TOL_RST(4)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .target_flat(target_flat), .fine_flat(fine_gain), .tol(tol)
  );

  vgc_line_timer #(.SETTLE_CLKS(SETTLE_CLKS)) u_timer (
    .clk(clk), .rst(rst), .hsync(hsync), .sample_stb(sample_stb)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vgc_chan_loop #(
      .ADC_W(ADC_W), .GAIN_W(GAIN_W), .TGT_W(TGT_W), .TOL_W(TOL_W),
      .LOCK_LINES(LOCK_LINES)
    ) u_loop (
      .clk(clk), .rst(rst), .sample_stb(sample_stb),
      .adc_code(adc_code[c*ADC_W +: ADC_W]),
      .target(target_flat[c*TGT_W +: TGT_W]),
      .tol(tol),
      .gain(coarse_gain[c*GAIN_W +: GAIN_W]),
      .locked(locked[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_live <= 1'b0;
    else     out_live <= 1'b1;
  end

  assign video_valid = out_live && !hsync;
endmodule

// File: rtl/vgc_servo_chk.sv
module vgc_servo_chk #(
  parameter int NCH    = 3,
  parameter int GAIN_W = 7,
  parameter int FINE_W = 5,
  parameter int TGT_W  = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  hsync,
  input logic                  wr_en,
  input logic                  video_valid,
  input logic [NCH*GAIN_W-1:0] coarse_gain,
  input logic [NCH*FINE_W-1:0] fine_gain,
  input logic [NCH-1:0]        locked,
  input logic [NCH*TGT_W-1:0]  target_flat
);
  // R7
  valid_low_in_sync_chk: assert property (@(posedge clk) disable iff (rst)
    hsync |-> !video_valid);

  // R3
  fine_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fine_gain) |-> $past(wr_en));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R4
    gain_single_step_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(coarse_gain[c*GAIN_W +: GAIN_W]) |->
        (coarse_gain[c*GAIN_W +: GAIN_W] == GAIN_W'($past(coarse_gain[c*GAIN_W +: GAIN_W]) + 1'b1)) ||
        (coarse_gain[c*GAIN_W +: GAIN_W] == GAIN_W'($past(coarse_gain[c*GAIN_W +: GAIN_W]) - 1'b1)));

    // R4
    gain_moves_in_sync_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(coarse_gain[c*GAIN_W +: GAIN_W]) |-> $past(hsync));

    // R2
    target_in_window_chk: assert property (@(posedge clk) disable iff (rst)
      (target_flat[c*TGT_W +: TGT_W] >= TGT_W'(32)) && (target_flat[c*TGT_W +: TGT_W] <= TGT_W'(99)));

    // R8
    lock_rise_in_sync_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(locked[c]) |-> $past(hsync));
  end
endmodule

bind vgc_gain_servo vgc_servo_chk #(
  .NCH(NCH), .GAIN_W(GAIN_W), .FINE_W(FINE_W), .TGT_W(TGT_W)
) u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .wr_en(wr_en), .video_valid(video_valid),
  .coarse_gain(coarse_gain), .fine_gain(fine_gain), .locked(locked),
  .target_flat(target_flat)
);

// File: tb/vgc_gain_servo_bench.sv
module vgc_gain_servo_bench;
  localparam int SETTLE = 3;
  localparam int LOCKN  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        hsync = 1'b0;
  logic [23:0] adc_code = '0;
  logic [20:0] coarse_gain;
  logic [14:0] fine_gain;
  logic [2:0]  locked;
  logic        video_valid;

  int n_chk = 0;
  int n_fail = 0;
  int eg[3], et[3], elk[3];
  int etol;

  always #2.5 clk = ~clk;

  vgc_gain_servo u_vgc_gain_servo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .adc_code(adc_code), .coarse_gain(coarse_gain),
    .fine_gain(fine_gain), .locked(locked), .video_valid(video_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; hsync = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 3; c++) begin eg[c] = 64; et[c] = 64; elk[c] = 0; end
    etol = 4;
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 8'(data);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic check_state(input string req);
    for (int c = 0; c < 3; c++) begin
      chk(coarse_gain[c*7 +: 7] == 7'(eg[c]), req, int'(coarse_gain[c*7 +: 7]), eg[c]);
      chk(locked[c] == (elk[c] == LOCKN), {req, " lock"}, int'(locked[c]), int'(elk[c] == LOCKN));
    end
  endtask

  // One full calibration line: junk during settling, then the real reference
  task automatic run_line(input int r, input int g, input int b, input string req);
    int s[3];
    s[0] = r; s[1] = g; s[2] = b;
    @(negedge clk);
    hsync = 1'b1;
    adc_code = {~8'(b), ~8'(g), ~8'(r)};
    repeat (SETTLE) @(negedge clk);
    adc_code = {8'(b), 8'(g), 8'(r)};
    chk(video_valid == 1'b0, "R7 sync", int'(video_valid), 0);
    repeat (2) @(negedge clk);
    hsync = 1'b0;
    adc_code = 24'hA5A5A5;
    @(negedge clk);
    chk(video_valid == 1'b1, "R7 live", int'(video_valid), 1);
    for (int c = 0; c < 3; c++) begin
      int d;
      if (s[c] < et[c] && eg[c] < 127) eg[c]++;
      else if (s[c] > et[c] && eg[c] > 0) eg[c]--;
      d = (s[c] > et[c]) ? s[c] - et[c] : et[c] - s[c];
      if (d <= etol) begin if (elk[c] < LOCKN) elk[c]++; end
      else elk[c] = 0;
    end
    check_state(req);
  endtask

  task automatic t_reset();   // R1
    do_reset();
    for (int c = 0; c < 3; c++)
      chk(coarse_gain[c*7 +: 7] == 7'd64, "R1 gain", int'(coarse_gain[c*7 +: 7]), 64);
    chk(fine_gain == '0, "R1 fine", int'(fine_gain), 0);
    chk(locked == '0, "R1 locked", int'(locked), 0);
    chk(video_valid == 1'b1, "R1 valid", int'(video_valid), 1);
  endtask

  task automatic t_fine();    // R3
    wr(5, 8'hF5);
    chk(fine_gain[9:5] == 5'd21, "R3 ch1", int'(fine_gain[9:5]), 21);
    chk(fine_gain[4:0] == 5'd0 && fine_gain[14:10] == 5'd0, "R3 others", int'(fine_gain), 21 << 5);
    wr(9, 3);
    chk(fine_gain[14:10] == 5'd3, "R3 ch2", int'(fine_gain[14:10]), 3);
  endtask

  task automatic t_direction(); // R4 R10
    run_line(50, 80, 64, "R4 dir");
    run_line(50, 80, 64, "R10 indep");
    run_line(70, 60, 64, "R4 reverse");
  endtask

  task automatic t_short();   // R6
    @(negedge clk); hsync = 1'b1; adc_code = {8'd0, 8'd255, 8'd0};
    repeat (SETTLE) @(negedge clk);
    hsync = 1'b0;
    @(negedge clk);
    check_state("R6 short pulse");
  endtask

  task automatic t_clamp();   // R2
    wr(0, 10); wr(4, 200); wr(8, 70);
    et[0] = 32; et[1] = 99; et[2] = 70;
    run_line(32, 99, 70, "R2 clamp hold");
    run_line(31, 100, 69, "R2 clamp edge");
  endtask

  task automatic t_saturate(); // R5
    wr(0, 99); et[0] = 99;
    for (int i = 0; i < 70; i++) run_line(0, 255, 70, "R5 saturate");
    chk(coarse_gain[6:0] == 7'd127, "R5 top", int'(coarse_gain[6:0]), 127);
    chk(coarse_gain[13:7] == 7'd0, "R5 bottom", int'(coarse_gain[13:7]), 0);
  endtask

  task automatic t_lock();    // R8 R9
    do_reset();
    for (int i = 0; i < LOCKN; i++) run_line(62, 64, 60, "R8 lock run");
    chk(locked == 3'b111, "R8 locked", int'(locked), 7);
    run_line(70, 64, 59, "R8 lose");
    chk(locked == 3'b010, "R8 lost", int'(locked), 2);
    wr(12, 10); etol = 10;
    for (int i = 0; i < LOCKN; i++) run_line(70, 64, 59, "R9 tolerance");
    chk(locked == 3'b111, "R9 wide", int'(locked), 7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fine();
    t_direction();
    t_short();
    t_clamp();
    t_saturate();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule